// File: doc/BRIEF.md
# Capture-Compare Timer with Port Actions

This block is a free-running 16-bit timer with a selectable input source and a power-of-two prescaler. Four capture channels latch the timer value on chosen edges of their pins. Three compare registers drive actions on an 8-bit output port: one sets the low six bits, one clears them, and one toggles the top two bits. Each action is gated per bit by an enable register. Each capture, each compare match and the timer overflow raises a sticky interrupt flag.

Software cannot load the timer. It returns to zero on system reset, while the idle input is high, or on a rising edge of the external timer-reset pin when that feature is enabled. A simple register interface, with one write port and one independent combinational read port, configures the block and reads back captures, the timer, the port and the flags. The port bits can also be written directly. When a compare action and a software write hit the same bit in the same cycle, the compare action wins.

Register map (the `reg_addr`/`rd_addr` value): 0 control, 1 capture edge selects, 2/3/4 compare 0/1/2, 5 set-enable, 6 clear/toggle-enable, 7 port, 8 flags, 9 timer (read only), 10 to 13 capture 0 to 3 (read only). Control bits: [1:0] division code, [3:2] source, [4] external reset enable, [5] low-byte overflow enable, [6] full overflow enable.

Top module: `cc_timer`

## Requirements
- R1: After reset the timer, all captures, the compare registers, the enables, the port and all flags are 0.
- R2: With division code d (control bits [1:0]), the timer advances by one for every 2^d prescaler input events, counted from a cleared prescaler.
- R3: Source code (control bits [3:2]) 1 counts cycles where `tick12` is high. Code 2 counts rising edges of `cnt_pin`. Codes 0 and 3 stop the timer, which then holds its value.
- R4: A control write that changes the division code or the source clears the prescaler.
- R5: When control bit 4 is 1, a rising edge on `trst_pin` zeroes the timer and the prescaler. When bit 4 is 0 the pin has no effect. A write to address 9 does not change the timer.
- R6: While `idle` is high the timer reads 0 and the prescaler is held cleared.
- R7: Edge-select bit 2i enables rising edges of `cap_pin[i]`, and bit 2i+1 enables falling edges. A selected edge copies the current timer value into capture i and sets flag bit i.
- R8: A channel with both of its edge-select bits at 0 never changes its capture register and never sets its flag.
- R9: When the timer increments onto compare 0, port bits 0 to 5 whose set-enable bit is 1 become 1. When it increments onto compare 1, port bits 0 to 5 whose clear/toggle-enable bit is 1 become 0. Each such match sets flag bit 4 (compare 0) or flag bit 5 (compare 1).
- R10: When the timer increments onto compare 2, port bits 6 and 7 whose clear/toggle-enable bit is 1 invert, and flag bit 6 is set.
- R11: Flag bit 7 is set when the low byte wraps from FF and control bit 5 is 1, or when all 16 bits wrap and control bit 6 is 1.
- R12: Writing the flags register clears the flag bits written as 1 and leaves the others unchanged. A hardware set in the same cycle wins over the clear.
- R13: A write to the port register loads it, except that any bit hit by a compare action in the same cycle takes the compare result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick12 | input | 1 | Prescaler input event at one twelfth of the clock |
| cnt_pin | input | 1 | External count pin, counted on rising edges |
| trst_pin | input | 1 | External timer reset pin, acts on rising edges |
| cap_pin | input | 4 | Capture input pins |
| idle | input | 1 | Idle mode; holds the timer and prescaler cleared |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Read data, combinational from rd_addr |
| port_out | output | 8 | Output port value |
| irq_flags | output | 8 | Sticky flags: [3:0] captures, [6:4] compares, [7] overflow |

## Verification
The assertions assume that `cnt_pin`, `trst_pin` and `cap_pin` are already synchronous to `clk`. They also assume that a control write never lands in the same cycle as a prescaler input event, so the next prescaler state is always taken from a known configuration. The stimulus changes every input only at the falling clock edge and issues register writes only between tick bursts. Two inputs meet in one cycle in just two places: a flag clear with a capture edge, and a port write with a toggle match. Both are the collisions that R12 and R13 define.

// File: rtl/cct_pkg.sv
package cct_pkg;
   typedef enum logic [1:0] {
      SRC_OFF  = 2'd0,
      SRC_TICK = 2'd1,
      SRC_PIN  = 2'd2,
      SRC_HOLD = 2'd3
   } src_e;

   typedef struct packed {
      logic       full_en;
      logic       lo_en;
      logic       xrst_en;
      src_e       src;
      logic [1:0] div;
   } ctrl_t;

   localparam int CTRL_W    = 7;
   localparam int ADR_CTRL  = 0;
   localparam int ADR_EDGE  = 1;
   localparam int ADR_CMP0  = 2;
   localparam int ADR_SETEN = 5;
   localparam int ADR_RTEN  = 6;
   localparam int ADR_PORT  = 7;
   localparam int ADR_FLAG  = 8;
   localparam int ADR_TIMER = 9;
   localparam int ADR_CAP0  = 10;
   localparam int NCMP      = 3;
endpackage

// File: rtl/cct_prescaler.sv
module cct_prescaler
   import cct_pkg::*;
#(
   parameter int DIVW = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  src_e            src,
   input  logic [DIVW-1:0] div,
   input  logic            clr,
   input  logic            tick12,
   input  logic            cnt_pin,
   output logic            step
);
   localparam int PRE_W = (1 << DIVW) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] div_m1;
   logic             pin_q;
   logic             ev;

   always_comb begin
      div_m1 = '0;
      for (int b = 0; b < PRE_W; b++) begin
         if (b < int'(div)) div_m1[b] = 1'b1;
      end
   end

   always_comb begin
      case (src)
         SRC_TICK: ev = tick12;
         SRC_PIN:  ev = cnt_pin & ~pin_q;
         default:  ev = 1'b0;
      endcase
   end

   assign step = ev & ~clr & (pre_q == div_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         pin_q <= 1'b0;
      end else begin
         pin_q <= cnt_pin;
         if (clr)
            pre_q <= '0;
         else if (ev)
            pre_q <= (pre_q == div_m1) ? '0 : pre_q + 1'b1;
      end
   end

   // R2: the division count never exceeds the selected factor
   p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q <= div_m1);

   // R4: a clear leaves the prescaler empty
   p_pre_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> pre_q == '0);
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   output logic [TW-1:0] value,
   output logic          lo_wrap,
   output logic          full_wrap
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         value <= '0;
      else if (clr)
         value <= '0;
      else if (step)
         value <= value + 1'b1;
   end

   assign lo_wrap   = step & (&value[7:0]);
   assign full_wrap = step & (&value);

   // R6 and R5: a clear always lands on zero
   p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> value == '0);
endmodule

// File: rtl/cct_capture.sv
module cct_capture #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pin,
   input  logic [1:0]    edge_sel,
   input  logic [TW-1:0] timer,
   output logic          fire,
   output logic [TW-1:0] cap_q
);
   logic pin_q;
   logic rise;
   logic fall;

   assign rise = pin & ~pin_q;
   assign fall = ~pin & pin_q;
   assign fire = (rise & edge_sel[0]) | (fall & edge_sel[1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b0;
         cap_q <= '0;
      end else begin
         pin_q <= pin;
         if (fire) cap_q <= timer;
      end
   end

   p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> cap_q == $past(timer));

   p_no_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel == 2'b00) |=> $stable(cap_q));
endmodule

// File: rtl/cct_port.sv
module cct_port #(
   parameter int PW   = 8,
   parameter int NSET = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sw_we,
   input  logic [PW-1:0]   sw_data,
   input  logic            set_hit,
   input  logic            clr_hit,
   input  logic            tog_hit,
   input  logic [NSET-1:0] set_en,
   input  logic [PW-1:0]   rt_en,
   output logic [PW-1:0]   port_q
);
   for (genvar b = 0; b < PW; b++) begin : g_bit
      logic bit_q;
      assign port_q[b] = bit_q;

      if (b < NSET) begin : g_setclr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (set_hit && set_en[b])
               bit_q <= 1'b1;
            else if (clr_hit && rt_en[b])
               bit_q <= 1'b0;
            else if (sw_we)
               bit_q <= sw_data[b];
         end

         p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_hit && set_en[b]) |=> bit_q);

         p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_hit && rt_en[b] && !(set_hit && set_en[b])) |=> !bit_q);
      end else begin : g_toggle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               bit_q <= 1'b0;
            else if (tog_hit && rt_en[b])
               bit_q <= ~bit_q;
            else if (sw_we)
               bit_q <= sw_data[b];
         end

         p_tog_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (tog_hit && rt_en[b]) |=> bit_q != $past(bit_q));

         p_sw_r13: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_we && !(tog_hit && rt_en[b])) |=> bit_q == $past(sw_data[b]));
      end
   end
endmodule

// File: rtl/cc_timer.sv
module cc_timer
   import cct_pkg::*;
#(
   parameter int TW   = 16,
   parameter int NCAP = 4,
   parameter int PW   = 8,
   parameter int NSET = 6,
   parameter int AW   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick12,
   input  logic               cnt_pin,
   input  logic               trst_pin,
   input  logic [NCAP-1:0]    cap_pin,
   input  logic               idle,
   input  logic               reg_we,
   input  logic [AW-1:0]      reg_addr,
   input  logic [TW-1:0]      reg_wdata,
   input  logic [AW-1:0]      rd_addr,
   output logic [TW-1:0]      rd_data,
   output logic [PW-1:0]      port_out,
   output logic [NCAP+3:0]    irq_flags
);
   localparam int FW      = NCAP + 4;
   localparam int FLG_CMP = NCAP;
   localparam int FLG_OVF = NCAP + 3;
   localparam int EW      = 2 * NCAP;

   if (TW < 9) begin : g_bad_tw
      $error("cc_timer: TW must cover a low byte plus at least one bit");
   end
   if (NSET < 1 || NSET >= PW) begin : g_bad_nset
      $error("cc_timer: NSET must leave at least one toggle bit");
   end
   if (EW > TW || PW > TW || CTRL_W > TW) begin : g_bad_ew
      $error("cc_timer: register fields must fit the data width");
   end
   if (ADR_CAP0 + NCAP > (1 << AW)) begin : g_bad_aw
      $error("cc_timer: address width too small for the capture channels");
   end

   ctrl_t           ctrl_q;
   ctrl_t           ctrl_new;
   logic [EW-1:0]   edge_q;
   logic [TW-1:0]   cmp_q [NCMP];
   logic [NSET-1:0] seten_q;
   logic [PW-1:0]   rten_q;
   logic [FW-1:0]   flag_q;
   logic [FW-1:0]   flag_set;
   logic [FW-1:0]   flag_clr;
   logic            trst_q;

   logic            we_ctrl, we_edge, we_seten, we_rten, we_port, we_flag;
   logic            cfg_change, trst_fire, tmr_clr, pre_clr;
   logic            step, lo_wrap, full_wrap, ovf_set;
   logic [TW-1:0]   timer;
   logic [TW-1:0]   nxt;
   logic [NCMP-1:0] cmp_hit;
   logic [NCAP-1:0] cap_fire;
   logic [TW-1:0]   cap_val [NCAP];

   assign we_ctrl  = reg_we && (reg_addr == AW'(ADR_CTRL));
   assign we_edge  = reg_we && (reg_addr == AW'(ADR_EDGE));
   assign we_seten = reg_we && (reg_addr == AW'(ADR_SETEN));
   assign we_rten  = reg_we && (reg_addr == AW'(ADR_RTEN));
   assign we_port  = reg_we && (reg_addr == AW'(ADR_PORT));
   assign we_flag  = reg_we && (reg_addr == AW'(ADR_FLAG));

   assign ctrl_new   = ctrl_t'(reg_wdata[CTRL_W-1:0]);
   assign cfg_change = we_ctrl && ((ctrl_new.div != ctrl_q.div) ||
                                   (ctrl_new.src != ctrl_q.src));
   assign trst_fire  = ctrl_q.xrst_en & trst_pin & ~trst_q;
   assign tmr_clr    = idle | trst_fire;
   assign pre_clr    = tmr_clr | cfg_change;

   cct_prescaler #(.DIVW(2)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (ctrl_q.src),
      .div     (ctrl_q.div),
      .clr     (pre_clr),
      .tick12  (tick12),
      .cnt_pin (cnt_pin),
      .step    (step)
   );

   cct_counter #(.TW(TW)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (tmr_clr),
      .step      (step),
      .value     (timer),
      .lo_wrap   (lo_wrap),
      .full_wrap (full_wrap)
   );

   assign nxt = timer + TW'(1);
   for (genvar k = 0; k < NCMP; k++) begin : g_cmp
      assign cmp_hit[k] = step && (nxt == cmp_q[k]);
   end

   for (genvar i = 0; i < NCAP; i++) begin : g_cap
      cct_capture #(.TW(TW)) u_cap (
         .clk      (clk),
         .rst_n    (rst_n),
         .pin      (cap_pin[i]),
         .edge_sel (edge_q[2*i +: 2]),
         .timer    (timer),
         .fire     (cap_fire[i]),
         .cap_q    (cap_val[i])
      );
   end

   cct_port #(.PW(PW), .NSET(NSET)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_we   (we_port),
      .sw_data (reg_wdata[PW-1:0]),
      .set_hit (cmp_hit[0]),
      .clr_hit (cmp_hit[1]),
      .tog_hit (cmp_hit[2]),
      .set_en  (seten_q),
      .rt_en   (rten_q),
      .port_q  (port_out)
   );

   assign ovf_set  = (lo_wrap & ctrl_q.lo_en) | (full_wrap & ctrl_q.full_en);
   assign flag_set = {ovf_set, cmp_hit, cap_fire};
   assign flag_clr = we_flag ? reg_wdata[FW-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         edge_q  <= '0;
         seten_q <= '0;
         rten_q  <= '0;
         flag_q  <= '0;
         trst_q  <= 1'b0;
         for (int k = 0; k < NCMP; k++) cmp_q[k] <= '0;
      end else begin
         trst_q <= trst_pin;
         flag_q <= (flag_q & ~flag_clr) | flag_set;
         if (we_ctrl)  ctrl_q  <= ctrl_new;
         if (we_edge)  edge_q  <= reg_wdata[EW-1:0];
         if (we_seten) seten_q <= reg_wdata[NSET-1:0];
         if (we_rten)  rten_q  <= reg_wdata[PW-1:0];
         for (int k = 0; k < NCMP; k++) begin
            if (reg_we && (reg_addr == AW'(ADR_CMP0 + k))) cmp_q[k] <= reg_wdata;
         end
      end
   end

   assign irq_flags = flag_q;

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         AW'(ADR_CTRL):  rd_data = TW'(ctrl_q);
         AW'(ADR_EDGE):  rd_data = TW'(edge_q);
         AW'(ADR_SETEN): rd_data = TW'(seten_q);
         AW'(ADR_RTEN):  rd_data = TW'(rten_q);
         AW'(ADR_PORT):  rd_data = TW'(port_out);
         AW'(ADR_FLAG):  rd_data = TW'(flag_q);
         AW'(ADR_TIMER): rd_data = timer;
         default: begin
            for (int k = 0; k < NCMP; k++) begin
               if (rd_addr == AW'(ADR_CMP0 + k)) rd_data = cmp_q[k];
            end
            for (int i = 0; i < NCAP; i++) begin
               if (rd_addr == AW'(ADR_CAP0 + i)) rd_data = cap_val[i];
            end
         end
      endcase
   end

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idle |=> timer == '0);

   p_xrst_r5: assert property (@(posedge clk) disable iff (!rst_n)
      trst_fire |=> timer == '0);

   p_nonload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == AW'(ADR_TIMER) && !step && !tmr_clr) |=> $stable(timer));

   p_off_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctrl_q.src == SRC_OFF || ctrl_q.src == SRC_HOLD) && !tmr_clr) |=> $stable(timer));

   p_ovf_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_set |=> flag_q[FLG_OVF]);

   p_cmp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_hit[0] |=> flag_q[FLG_CMP]);

   p_flag_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !we_flag |=> (flag_q & $past(flag_q)) == $past(flag_q));
endmodule

// File: tb/tb_cc_timer.sv
module tb_cc_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick12 = 1'b0;
   logic        cnt_pin = 1'b0;
   logic        trst_pin = 1'b0;
   logic [3:0]  cap_pin = 4'h0;
   logic        idle = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = 4'h0;
   logic [15:0] reg_wdata = 16'h0;
   logic [3:0]  rd_addr = 4'h0;
   logic [15:0] rd_data;
   logic [7:0]  port_out;
   logic [7:0]  irq_flags;

   int n_chk = 0;
   int n_fail = 0;

   cc_timer dut (
      .clk(clk), .rst_n(rst_n), .tick12(tick12), .cnt_pin(cnt_pin),
      .trst_pin(trst_pin), .cap_pin(cap_pin), .idle(idle), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
      .rd_data(rd_data), .port_out(port_out), .irq_flags(irq_flags)
   );

   always #5 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [15:0] v);
      rd_addr = 4'(a);
      #1;
      v = rd_data;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick12 = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick12 = 1'b0;
   endtask

   task automatic cnt_pulse();
      @(negedge clk); cnt_pin = 1'b1;
      @(negedge clk); cnt_pin = 1'b0;
   endtask

   task automatic xreset();
      @(negedge clk); trst_pin = 1'b1;
      @(negedge clk); trst_pin = 1'b0;
   endtask

   task automatic set_cap(input int ch, input logic val);
      @(negedge clk); cap_pin[ch] = val;
      @(negedge clk);
   endtask

   function automatic logic [15:0] mk(int d, int s, int x, int lo, int full);
      return 16'(d | (s << 2) | (x << 4) | (lo << 5) | (full << 6));
   endfunction

   task automatic chk_timer(input string req, input int exp);
      logic [15:0] v;
      rd(9, v);
      chk(req, v, exp);
   endtask

   initial begin
      #1_500_000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int tmr;
      logic [15:0] capexp [4];

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_timer("R1 timer", 0);
      chk("R1 port", port_out, 0);
      chk("R1 flags", irq_flags, 0);
      rd(0, v);  chk("R1 ctrl", v, 0);
      rd(10, v); chk("R1 cap0", v, 0);
      rd(3, v);  chk("R1 cmp1", v, 0);

      // R2 prescaler sweep over every division code
      for (int d = 0; d < 4; d++) begin
         wr(0, mk(d, 1, 1, 0, 0));
         xreset();
         for (int n = 1; n <= 12; n++) begin
            ticks(1);
            chk_timer($sformatf("R2 d=%0d n=%0d", d, n), n >> d);
         end
      end

      // R3 source off holds, pin source counts rising edges only
      wr(0, mk(0, 0, 1, 0, 0));
      ticks(5);
      chk_timer("R3 off holds", 1);
      wr(0, mk(0, 3, 1, 0, 0));
      ticks(3);
      chk_timer("R3 code3 holds", 1);
      wr(0, mk(0, 2, 1, 0, 0));
      xreset();
      for (int n = 1; n <= 7; n++) begin
         cnt_pulse();
         chk_timer($sformatf("R3 pin n=%0d", n), n);
      end
      ticks(3);
      chk_timer("R3 pin ignores tick", 7);
      wr(0, mk(1, 2, 1, 0, 0));
      xreset();
      for (int n = 1; n <= 6; n++) begin
         cnt_pulse();
         chk_timer($sformatf("R3 pin div2 n=%0d", n), n >> 1);
      end

      // R4 config change clears prescaler
      wr(0, mk(3, 1, 1, 0, 0));
      xreset();
      ticks(5);
      chk_timer("R4 before change", 0);
      wr(0, mk(2, 1, 1, 0, 0));
      ticks(3);
      chk_timer("R4 three after change", 0);
      ticks(1);
      chk_timer("R4 four after change", 1);

      // R5 disabled external reset and write to timer address
      wr(0, mk(0, 1, 1, 0, 0));
      xreset();
      ticks(4);
      wr(0, mk(0, 1, 0, 0, 0));
      xreset();
      chk_timer("R5 xrst disabled", 4);
      wr(9, 16'h1234);
      chk_timer("R5 not loadable", 4);
      wr(0, mk(0, 1, 1, 0, 0));
      xreset();
      chk_timer("R5 xrst enabled", 0);

      // R6 idle clears timer and prescaler
      wr(0, mk(1, 1, 1, 0, 0));
      xreset();
      ticks(5);
      chk_timer("R6 before idle", 2);
      @(negedge clk); idle = 1'b1;
      ticks(3);
      chk_timer("R6 during idle", 0);
      @(negedge clk); idle = 1'b0;
      ticks(1);
      chk_timer("R6 prescaler cleared", 0);
      ticks(1);
      chk_timer("R6 counts again", 1);

      // R7 and R8 capture edge selection on each channel
      wr(0, mk(0, 1, 1, 0, 0));
      xreset();
      tmr = 0;
      for (int i = 0; i < 4; i++) capexp[i] = 16'h0;
      for (int i = 0; i < 4; i++) begin
         wr(1, 16'h0);
         wr(8, 16'hFF);
         ticks(i + 1); tmr += i + 1;
         set_cap(i, 1'b1);
         rd(10 + i, v); chk($sformatf("R8 ch%0d rise none", i), v, capexp[i]);
         chk($sformatf("R8 ch%0d flag", i), irq_flags[i], 0);
         set_cap(i, 1'b0);
         rd(10 + i, v); chk($sformatf("R8 ch%0d fall none", i), v, capexp[i]);
         chk($sformatf("R8 ch%0d flag2", i), irq_flags[i], 0);

         wr(1, 16'(1 << (2 * i)));
         ticks(1); tmr++;
         set_cap(i, 1'b1);
         capexp[i] = 16'(tmr);
         rd(10 + i, v); chk($sformatf("R7 ch%0d rise", i), v, capexp[i]);
         chk($sformatf("R7 ch%0d flag", i), irq_flags[i], 1);
         ticks(1); tmr++;
         set_cap(i, 1'b0);
         rd(10 + i, v); chk($sformatf("R7 ch%0d fall ignored", i), v, capexp[i]);

         wr(1, 16'(2 << (2 * i)));
         ticks(1); tmr++;
         set_cap(i, 1'b1);
         rd(10 + i, v); chk($sformatf("R7 ch%0d rise ignored", i), v, capexp[i]);
         set_cap(i, 1'b0);
         capexp[i] = 16'(tmr);
         rd(10 + i, v); chk($sformatf("R7 ch%0d fall", i), v, capexp[i]);

         wr(1, 16'(3 << (2 * i)));
         ticks(1); tmr++;
         set_cap(i, 1'b1);
         capexp[i] = 16'(tmr);
         rd(10 + i, v); chk($sformatf("R7 ch%0d both rise", i), v, capexp[i]);
         ticks(1); tmr++;
         set_cap(i, 1'b0);
         capexp[i] = 16'(tmr);
         rd(10 + i, v); chk($sformatf("R7 ch%0d both fall", i), v, capexp[i]);
      end

      // R12 flag clearing
      wr(1, 16'h00FF);
      wr(8, 16'hFF);
      for (int i = 0; i < 4; i++) begin
         @(negedge clk); cap_pin[i] = 1'b1;
      end
      @(negedge clk);
      chk("R12 all cap flags", irq_flags, 8'h0F);
      wr(8, 16'h01);
      chk("R12 selective clear", irq_flags, 8'h0E);
      wr(8, 16'h00);
      chk("R12 zero write keeps", irq_flags, 8'h0E);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = 16'h02; cap_pin[1] = 1'b0;
      @(negedge clk);
      reg_we = 1'b0;
      chk("R12 set wins over clear", irq_flags, 8'h0E);
      wr(8, 16'hFF);
      chk("R12 clear all", irq_flags, 8'h00);
      wr(1, 16'h0000);
      cap_pin = 4'h0;

      // R9 and R10 compare actions on the port
      wr(7, 16'h00);
      wr(5, 16'h2A);
      wr(6, 16'h46);
      wr(2, 16'd5);
      wr(3, 16'd8);
      wr(4, 16'd10);
      xreset();
      wr(8, 16'hFF);
      ticks(4);
      chk("R9 before cmp0", port_out, 8'h00);
      chk("R9 no cmp flags", irq_flags & 8'h70, 8'h00);
      ticks(1);
      chk("R9 cmp0 set", port_out, 8'h2A);
      chk("R9 cmp0 flag", irq_flags & 8'h70, 8'h10);
      ticks(3);
      chk("R9 cmp1 clear", port_out, 8'h28);
      chk("R9 cmp1 flag", irq_flags & 8'h70, 8'h30);
      ticks(2);
      chk("R10 cmp2 toggle", port_out, 8'h68);
      chk("R10 cmp2 flag", irq_flags & 8'h70, 8'h70);
      xreset();
      ticks(10);
      chk("R10 second toggle", port_out, 8'h28);

      // R13 compare action beats software write
      xreset();
      ticks(9);
      chk("R13 setup", port_out, 8'h28);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 4'd7; reg_wdata = 16'h81; tick12 = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; tick12 = 1'b0;
      chk("R13 toggle wins", port_out, 8'hC1);
      wr(7, 16'h55);
      chk("R13 plain write", port_out, 8'h55);

      // R11 overflow flag and its enables
      wr(0, mk(0, 1, 1, 1, 0));
      xreset();
      wr(8, 16'hFF);
      ticks(255);
      chk("R11 before low wrap", irq_flags[7], 0);
      ticks(1);
      chk_timer("R11 timer 0x100", 16'h100);
      chk("R11 low wrap flag", irq_flags[7], 1);
      wr(8, 16'hFF);
      wr(0, mk(0, 1, 1, 0, 1));
      ticks(256);
      chk_timer("R11 timer 0x200", 16'h200);
      chk("R11 low wrap disabled", irq_flags[7], 0);
      ticks(65536 - 512 - 1);
      chk_timer("R11 timer top", 16'hFFFF);
      chk("R11 before full wrap", irq_flags[7], 0);
      ticks(1);
      chk_timer("R11 timer wrapped", 0);
      chk("R11 full wrap flag", irq_flags[7], 1);

      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule